// File: doc/BRIEF.md
# Compare/Capture Channel Value Register

This block is one channel of a general-purpose timer. It holds a 16-bit channel value that software reaches one byte at a time over an 8-bit register bus. The free-running counter and its prescaler tick are built elsewhere and arrive as inputs. The channel works in one of two modes:

- **Compare mode:** the value register is checked against the counter on every tick. A match sets a sticky channel flag.
- **Capture mode:** a selected edge on an external pin copies the counter into the value register and sets the same flag.

The bus side has two small state machines.

- **Write staging FSM.** Its states are `W_IDLE`, `W_HI` and `W_PEND`. It collects a high-then-low byte pair into a staging buffer. The pair reaches the value register in one of two ways:
  - at once, when the counter clock is switched off;
  - on the next counter tick, when the counter clock is running.

  Its transitions are:
  - *stage-high*: `W_IDLE`/`W_PEND`→`W_HI`
  - *restage-high*: `W_HI`→`W_HI`
  - *abort*: `W_HI`→`W_IDLE` on a control write
  - *commit-now*: `W_HI`→`W_IDLE`
  - *arm*: `W_HI`→`W_PEND`
  - *commit-on-tick*: `W_PEND`→`W_IDLE`

  In capture mode the staging FSM ignores all value writes.
- **Read latch FSM.** Its states are `R_IDLE`, `R_HI` and `R_LO`. It keeps a two-byte read coherent. The first byte read snapshots the whole value, and the second byte read is served from that snapshot. Its transitions are:
  - *snap-high*: `R_IDLE`→`R_HI`
  - *snap-low*: `R_IDLE`→`R_LO`
  - *release*: `R_HI`/`R_LO`→`R_IDLE` on reading the other byte
  - *debug-clear*: any state →`R_IDLE` on a control write during debug freeze

  During debug freeze, reads show the live value and leave the latch alone.

Top module: `cc_chan_reg`

## Requirements
- R1: After reset the value register, flag, mode bit (0), edge select (00), and both FSMs are zero/idle, so every bus address reads 0x00.
- R2: While the mode bit is 0 (capture), bus writes to the value bytes (address 1 high, address 2 low) never change the value register.
- R3: In compare mode with `clk_sel` not 00, a high write followed by a low write arms the pair; the value register takes the pair at the rising edge that ends the first cycle with `cnt_tick`=1 after the cycle of the low write (a tick in the low-write cycle itself does not commit).
- R4: In compare mode with `clk_sel` = 00, the value register takes {high byte, low byte} at the same rising edge that accepts the low-byte write.
- R5: A low write with no preceding high write is ignored; a control write (address 0) between the high and low writes discards the half pair; a high write while a pair is armed discards the armed pair, except that a tick in that same cycle still commits the armed pair first.
- R6: With debug freeze off, reading one value byte from an idle latch returns the live byte and snapshots all 16 bits; the value bytes then read from the snapshot until the other byte is read, which returns to live reads.
- R7: While `dbg_freeze`=1, address 1/2 always read the live value register, and reads leave the latch state unchanged.
- R8: A control write while `dbg_freeze`=1 returns the read latch to idle.
- R9: In compare mode, a cycle with `cnt_tick`=1 and `cnt_val` equal to the value register sets the flag at that edge; the flag stays set until cleared.
- R10: A control write with bit 7 = 1 clears the flag, but a flag-set event in the same cycle wins.
- R11: In capture mode, edge select bit 1 (address 0 bit 1) enables rising and bit 2 enables falling edges of `cap_pin`; after a two-flop synchronizer, a selected edge copies `cnt_val` into the value register and sets the flag at the second edge after the first flop samples the new level.
- R12: Address 0 reads {flag, 4'b0, edge select[1:0], mode}, address 1 the high value byte, address 2 the low value byte, address 3 reads 0x00; `bus_rdata` follows `bus_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the read latch) |
| bus_addr | input | 2 | 0 control, 1 value high, 2 value low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| clk_sel | input | 2 | Counter clock select, 00 = counter clock off |
| cnt_tick | input | 1 | One-cycle pulse on each counter change |
| cnt_val | input | 16 | Current counter value |
| dbg_freeze | input | 1 | Debug freeze active |
| cap_pin | input | 1 | Asynchronous capture input |
| chan_flag | output | 1 | Sticky channel event flag |
| chan_value | output | 16 | Value register contents |

## Verification
Results land at different edges:

- `bus_rdata` is combinational, so it is valid in the same cycle as the address.
- Value and flag updates from bus writes and compare hits appear right after the rising edge that samples the causing cycle.
- An armed pair appears only after the edge that closes its first tick cycle.
- A capture appears two edges after the first synchronizer flop sees the pin change.

The bench drives inputs just after each falling edge and steps its reference model on each rising edge. It compares `bus_rdata`, `chan_flag` and `chan_value` at the following falling edge, so every result is checked in the exact cycle it is due.

// File: rtl/cc_chan_pkg.sv
package cc_chan_pkg;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_HI   = 2'd1,
        W_PEND = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        R_IDLE = 2'd0,
        R_HI   = 2'd1,
        R_LO   = 2'd2
    } rd_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_VHI  = 2'd1;
    localparam logic [1:0] ADDR_VLO  = 2'd2;

endpackage

// File: rtl/cc_wr_stage.sv
module cc_wr_stage
    import cc_chan_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmp_mode_i,
    input  logic                  imm_i,
    input  logic                  tick_i,
    input  logic                  wr_hi_i,
    input  logic                  wr_lo_i,
    input  logic                  ctrl_wr_i,
    input  logic [BYTE_W-1:0]     wdata_i,
    output logic                  commit_o,
    output logic [2*BYTE_W-1:0]   commit_val_o
);

    wr_state_e         st_q, st_d;
    logic [BYTE_W-1:0] buf_hi_q, buf_lo_q;
    logic              hi_take, lo_take;

    // byte writes are only accepted in compare mode; low needs a staged high
    assign hi_take = cmp_mode_i && wr_hi_i;
    assign lo_take = cmp_mode_i && wr_lo_i && (st_q == W_HI);

    // state register and staging buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= W_IDLE;
            buf_hi_q <= '0;
            buf_lo_q <= '0;
        end else begin
            st_q <= st_d;
            if (hi_take) buf_hi_q <= wdata_i;
            if (lo_take) buf_lo_q <= wdata_i;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            W_IDLE: if (hi_take) st_d = W_HI;
            W_HI: begin
                if (ctrl_wr_i)    st_d = W_IDLE;
                else if (lo_take) st_d = imm_i ? W_IDLE : W_PEND;
            end
            W_PEND: begin
                if (hi_take)     st_d = W_HI;
                else if (tick_i) st_d = W_IDLE;
            end
            default: st_d = W_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit_o     = 1'b0;
        commit_val_o = {buf_hi_q, wdata_i};
        unique case (st_q)
            W_HI:    commit_o = lo_take && imm_i;
            W_PEND: begin
                commit_o     = tick_i;
                commit_val_o = {buf_hi_q, buf_lo_q};
            end
            default: commit_o = 1'b0;
        endcase
    end

    // R3
    armed_waits_for_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == W_PEND && !tick_i && !hi_take) |=> (st_q == W_PEND));

    // R5
    ctrl_aborts_half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == W_HI && ctrl_wr_i) |=> (st_q == W_IDLE));

endmodule

// File: rtl/cc_rd_latch.sv
module cc_rd_latch
    import cc_chan_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_hi_i,
    input  logic                  rd_lo_i,
    input  logic                  freeze_i,
    input  logic                  ctrl_wr_i,
    input  logic [2*BYTE_W-1:0]   live_i,
    output logic [BYTE_W-1:0]     hi_o,
    output logic [BYTE_W-1:0]     lo_o
);

    localparam int VAL_W = 2 * BYTE_W;

    rd_state_e        st_q, st_d;
    logic [VAL_W-1:0] snap_q;
    logic             snap_en;

    assign snap_en = (st_q == R_IDLE) && !freeze_i && (rd_hi_i || rd_lo_i);

    // state register and snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= R_IDLE;
            snap_q <= '0;
        end else begin
            st_q <= st_d;
            if (snap_en) snap_q <= live_i;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (freeze_i) begin
            if (ctrl_wr_i) st_d = R_IDLE;
        end else begin
            unique case (st_q)
                R_IDLE: begin
                    if (rd_hi_i)      st_d = R_HI;
                    else if (rd_lo_i) st_d = R_LO;
                end
                R_HI:    if (rd_lo_i) st_d = R_IDLE;
                R_LO:    if (rd_hi_i) st_d = R_IDLE;
                default: st_d = R_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        if (freeze_i || st_q == R_IDLE) begin
            hi_o = live_i[VAL_W-1:BYTE_W];
            lo_o = live_i[BYTE_W-1:0];
        end else begin
            hi_o = snap_q[VAL_W-1:BYTE_W];
            lo_o = snap_q[BYTE_W-1:0];
        end
    end

    // R7
    freeze_holds_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !ctrl_wr_i) |=> $stable(st_q));

    // R8
    freeze_ctrl_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && ctrl_wr_i) |=> (st_q == R_IDLE));

endmodule

// File: rtl/cc_edge_cap.sv
module cc_edge_cap #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] edge_sel_i,
    output logic       hit_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    generate
        if (SYNC_STAGES == 1) begin : gen_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : gen_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    assign hit_o = (edge_sel_i[0] && cur && !prev_q) ||
                   (edge_sel_i[1] && !cur && prev_q);

endmodule

// File: rtl/cc_chan_reg.sv
module cc_chan_reg
    import cc_chan_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [1:0]            bus_addr,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    input  logic [1:0]            clk_sel,
    input  logic                  cnt_tick,
    input  logic [2*BYTE_W-1:0]   cnt_val,
    input  logic                  dbg_freeze,
    input  logic                  cap_pin,
    output logic                  chan_flag,
    output logic [2*BYTE_W-1:0]   chan_value
);

    localparam int VAL_W    = 2 * BYTE_W;
    localparam int FLAG_BIT = BYTE_W - 1;

    logic             mode_q;
    logic [1:0]       edge_q;
    logic             flag_q;
    logic [VAL_W-1:0] value_q;

    logic             ctrl_wr, wr_hi, wr_lo, rd_hi, rd_lo;
    logic             commit, cap_raw, cap_hit, match, flag_set, flag_clr;
    logic [VAL_W-1:0] commit_val;
    logic [BYTE_W-1:0] rd_hi_byte, rd_lo_byte;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_hi   = bus_wr && (bus_addr == ADDR_VHI);
    assign wr_lo   = bus_wr && (bus_addr == ADDR_VLO);
    assign rd_hi   = bus_rd && (bus_addr == ADDR_VHI);
    assign rd_lo   = bus_rd && (bus_addr == ADDR_VLO);

    cc_wr_stage #(.BYTE_W(BYTE_W)) u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_mode_i   (mode_q),
        .imm_i        (clk_sel == 2'b00),
        .tick_i       (cnt_tick),
        .wr_hi_i      (wr_hi),
        .wr_lo_i      (wr_lo),
        .ctrl_wr_i    (ctrl_wr),
        .wdata_i      (bus_wdata),
        .commit_o     (commit),
        .commit_val_o (commit_val)
    );

    cc_rd_latch #(.BYTE_W(BYTE_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_hi_i   (rd_hi),
        .rd_lo_i   (rd_lo),
        .freeze_i  (dbg_freeze),
        .ctrl_wr_i (ctrl_wr),
        .live_i    (value_q),
        .hi_o      (rd_hi_byte),
        .lo_o      (rd_lo_byte)
    );

    cc_edge_cap #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (cap_pin),
        .edge_sel_i (edge_q),
        .hit_o      (cap_raw)
    );

    assign cap_hit  = cap_raw && !mode_q;
    assign match    = mode_q && cnt_tick && (cnt_val == value_q);
    assign flag_set = match || cap_hit;
    assign flag_clr = ctrl_wr && bus_wdata[FLAG_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            edge_q  <= 2'b00;
            flag_q  <= 1'b0;
            value_q <= '0;
        end else begin
            if (ctrl_wr) begin
                mode_q <= bus_wdata[0];
                edge_q <= bus_wdata[2:1];
            end
            flag_q <= flag_set || (flag_q && !flag_clr);
            if (cap_hit)     value_q <= cnt_val;
            else if (commit) value_q <= commit_val;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = {flag_q, {(BYTE_W-4){1'b0}}, edge_q, mode_q};
            ADDR_VHI:  bus_rdata = rd_hi_byte;
            ADDR_VLO:  bus_rdata = rd_lo_byte;
            default:   bus_rdata = '0;
        endcase
    end

    assign chan_flag  = flag_q;
    assign chan_value = value_q;

    // R2
    capture_blocks_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && bus_wr && bus_addr != ADDR_CTRL && !cap_hit && !commit)
        |=> $stable(chan_value));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_flag && !(ctrl_wr && bus_wdata[FLAG_BIT])) |=> chan_flag);

    // R11
    capture_loads_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (chan_flag && chan_value == $past(cnt_val)));

    // R4
    immediate_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !cap_hit) |=> (chan_value == $past(commit_val)));

endmodule

// File: tb/cc_chan_reg_bench.sv
module cc_chan_reg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [1:0]  clk_sel = 2'b00;
    logic        cnt_tick = 1'b0;
    logic [15:0] cnt_val = 16'h0000;
    logic        dbg_freeze = 1'b0;
    logic        cap_pin = 1'b0;
    logic        chan_flag;
    logic [15:0] chan_value;

    int    vectors = 0;
    int    errors  = 0;
    bit    armed   = 1'b0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_chan_reg u_cc_chan_reg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_sel(clk_sel), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
        .dbg_freeze(dbg_freeze), .cap_pin(cap_pin),
        .chan_flag(chan_flag), .chan_value(chan_value)
    );

    // ---------------- reference model ----------------
    int        m_val, m_flag, m_mode, m_edge;
    int        m_wst;           // 0 none staged, 1 high staged, 2 pair armed
    int        m_whi, m_wlo;
    int        m_rst;           // 0 live, 1 snapped by high read, 2 by low read
    int        m_snap;
    bit        m_pin [0:SYNC];  // synchronizer history plus previous level

    always @(posedge clk or negedge rst_n) begin : model
        bit wc, wh, wl, rh, rl, hi_ok, lo_ok, cap, commit, set, cur, prv;
        int cv, nval;
        if (!rst_n) begin
            m_val = 0; m_flag = 0; m_mode = 0; m_edge = 0;
            m_wst = 0; m_whi = 0; m_wlo = 0; m_rst = 0; m_snap = 0;
            for (int i = 0; i <= SYNC; i++) m_pin[i] = 1'b0;
        end else begin
            wc = bus_wr && bus_addr == 2'd0;
            wh = bus_wr && bus_addr == 2'd1;
            wl = bus_wr && bus_addr == 2'd2;
            rh = bus_rd && bus_addr == 2'd1;
            rl = bus_rd && bus_addr == 2'd2;
            cur = m_pin[SYNC-1];
            prv = m_pin[SYNC];
            cap = (m_mode == 0) && ((m_edge[0] && cur && !prv) || (m_edge[1] && !cur && prv));
            hi_ok = (m_mode != 0) && wh;
            lo_ok = (m_mode != 0) && wl && m_wst == 1;
            commit = (m_wst == 1 && lo_ok && clk_sel == 2'b00) || (m_wst == 2 && cnt_tick);
            cv = (m_wst == 2) ? ((m_whi << 8) | m_wlo) : ((m_whi << 8) | int'(bus_wdata));
            set = ((m_mode != 0) && cnt_tick && int'(cnt_val) == m_val) || cap;
            nval = cap ? int'(cnt_val) : (commit ? cv : m_val);
            // read coherency
            if (dbg_freeze) begin
                if (wc) m_rst = 0;
            end else if (m_rst == 0) begin
                if (rh || rl) m_snap = m_val;
                if (rh) m_rst = 1; else if (rl) m_rst = 2;
            end else if ((m_rst == 1 && rl) || (m_rst == 2 && rh)) begin
                m_rst = 0;
            end
            // write pairing
            case (m_wst)
                0: if (hi_ok) m_wst = 1;
                1: if (wc) m_wst = 0; else if (lo_ok) m_wst = (clk_sel == 2'b00) ? 0 : 2;
                default: if (hi_ok) m_wst = 1; else if (cnt_tick) m_wst = 0;
            endcase
            if (hi_ok) m_whi = int'(bus_wdata);
            if (lo_ok) m_wlo = int'(bus_wdata);
            m_flag = (set || (m_flag != 0 && !(wc && bus_wdata[7]))) ? 1 : 0;
            m_val = nval;
            if (wc) begin m_mode = int'(bus_wdata[0]); m_edge = int'(bus_wdata[2:1]); end
            for (int i = SYNC; i > 0; i--) m_pin[i] = m_pin[i-1];
            m_pin[0] = cap_pin;
        end
    end

    function automatic int exp_rdata();
        int src;
        src = (dbg_freeze || m_rst == 0) ? m_val : m_snap;
        case (bus_addr)
            2'd0: return (m_flag << 7) | ((m_edge & 3) << 1) | (m_mode & 1);
            2'd1: return (src >> 8) & 8'hFF;
            2'd2: return src & 8'hFF;
            default: return 0;
        endcase
    endfunction

    // ---------------- comparison every cycle ----------------
    always @(negedge clk) begin
        if (armed && !done) begin
            vectors++;
            if (int'(chan_value) != (m_val & 16'hFFFF)) begin
                errors++;
                $display("FAIL %s chan_value actual=%h expected=%h t=%0t", cur_req, chan_value, m_val[15:0], $time);
            end
            if (int'(chan_flag) != m_flag) begin
                errors++;
                $display("FAIL %s chan_flag actual=%0d expected=%0d t=%0t", cur_req, chan_flag, m_flag, $time);
            end
            if (int'(bus_rdata) != exp_rdata()) begin
                errors++;
                $display("FAIL %s bus_rdata addr=%0d actual=%h expected=%h t=%0t", cur_req, bus_addr, bus_rdata, exp_rdata(), $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic nxt();
        @(negedge clk); #2;
    endtask
    task automatic idle(input int n);
        repeat (n) nxt();
    endtask
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; nxt(); bus_wr = 1'b0;
    endtask
    task automatic rd(input logic [1:0] a);
        bus_rd = 1'b1; bus_addr = a; nxt(); bus_rd = 1'b0;
    endtask
    task automatic tk(input logic [15:0] c);
        cnt_val = c; cnt_tick = 1'b1; nxt(); cnt_tick = 1'b0;
    endtask
    task automatic pulse_pin();
        cap_pin = 1'b1; idle(4); cap_pin = 1'b0; idle(4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired in %s", cur_req);
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        @(posedge clk); armed = 1'b1;
        idle(3); rst_n = 1'b1;
        // R1 reset state on every address
        cur_req = "R1";
        for (int a = 0; a < 4; a++) begin bus_addr = 2'(a); idle(1); end
        // R12 control readback and address map
        cur_req = "R12";
        wr(2'd0, 8'h07); bus_addr = 2'd0; idle(1); bus_addr = 2'd3; idle(1);
        wr(2'd0, 8'h00);
        // R2 capture mode ignores value writes
        cur_req = "R2";
        wr(2'd1, 8'h55); wr(2'd2, 8'h66); clk_sel = 2'b01; tk(16'h0001); idle(2);
        // R4 immediate update with counter clock off
        cur_req = "R4";
        clk_sel = 2'b00; wr(2'd0, 8'h01); wr(2'd1, 8'h12); wr(2'd2, 8'h34); idle(1);
        // R3 deferred update at next tick
        cur_req = "R3";
        clk_sel = 2'b01; wr(2'd1, 8'hAB);
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'hCD; cnt_val = 16'h0010; cnt_tick = 1'b1;
        nxt(); bus_wr = 1'b0; cnt_tick = 1'b0;
        idle(2); tk(16'h0011); idle(1);
        // R5 pairing rules
        cur_req = "R5";
        wr(2'd2, 8'h99); tk(16'h0020);
        wr(2'd1, 8'h77); wr(2'd0, 8'h01); wr(2'd2, 8'h88); tk(16'h0021);
        wr(2'd1, 8'h01); wr(2'd2, 8'h02); wr(2'd1, 8'h03); tk(16'h0022); wr(2'd2, 8'h04); tk(16'h0023);
        wr(2'd1, 8'h05); wr(2'd2, 8'h06);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h07; cnt_val = 16'h0024; cnt_tick = 1'b1;
        nxt(); bus_wr = 1'b0; cnt_tick = 1'b0;
        wr(2'd2, 8'h08); tk(16'h0025); idle(1);
        // R9 compare flag
        cur_req = "R9";
        tk(16'h0707); tk(16'h0708); idle(2); tk(16'h0000); bus_addr = 2'd0; idle(1);
        // R10 flag clear and set priority
        cur_req = "R10";
        wr(2'd0, 8'h81); bus_addr = 2'd0; idle(1);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h81; cnt_val = 16'h0708; cnt_tick = 1'b1;
        nxt(); bus_wr = 1'b0; cnt_tick = 1'b0; idle(1);
        wr(2'd0, 8'h81); idle(1);
        // R6 coherent reads
        cur_req = "R6";
        clk_sel = 2'b00;
        rd(2'd1); wr(2'd1, 8'h11); wr(2'd2, 8'h22);
        bus_addr = 2'd1; idle(1); rd(2'd1); rd(2'd2); bus_addr = 2'd2; idle(1);
        rd(2'd2); wr(2'd1, 8'h5A); wr(2'd2, 8'hA5); rd(2'd1); bus_addr = 2'd1; idle(1);
        // R7 freeze shows live value, latch untouched
        cur_req = "R7";
        rd(2'd1); wr(2'd1, 8'h33); wr(2'd2, 8'h44);
        dbg_freeze = 1'b1; bus_addr = 2'd1; idle(1); rd(2'd2); rd(2'd1);
        dbg_freeze = 1'b0; bus_addr = 2'd2; idle(1); rd(2'd2); bus_addr = 2'd1; idle(1);
        // R8 control write in freeze clears latch
        cur_req = "R8";
        rd(2'd1); wr(2'd2, 8'h00); wr(2'd1, 8'h66); wr(2'd2, 8'h77);
        dbg_freeze = 1'b1; wr(2'd0, 8'h01); dbg_freeze = 1'b0;
        bus_addr = 2'd1; idle(1); bus_addr = 2'd2; idle(1);
        // R11 capture edges
        cur_req = "R11";
        wr(2'd0, 8'h02); cnt_val = 16'h4321; pulse_pin();
        wr(2'd0, 8'h84); cnt_val = 16'h1357; pulse_pin();
        wr(2'd0, 8'h86); cnt_val = 16'h2468; pulse_pin();
        wr(2'd0, 8'h80); cnt_val = 16'hBEEF; pulse_pin();
        bus_addr = 2'd0; idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule